// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing Register Bank

This block is the per-channel register bank of a scatter-gather DMA engine. Software reaches it through a simple 32-bit register port with separate read and write strobes. Each of the two channels owns a control register, a status register, a current-descriptor pointer and a tail-descriptor pointer. The datapath that fetches descriptors and moves data sits outside the block. It reports each finished packet with a one-cycle completion pulse and reports that it has caught up with the tail pointer with a one-cycle idle pulse. In return the block drives run, halted and idle levels and one interrupt line per channel.

Interrupts are coalesced in two ways. A completion counter raises the completion interrupt on every Nth finished packet, where N is set in the control register. A delay timer raises the delay interrupt when no further completion has arrived for a programmed number of timer ticks. A small prescaler per channel generates those ticks. The live values of both counters can be read back through the status register, so software can see how far coalescing has progressed. Both channels sit in one address window, and the channel is picked by bit 0 of the address divided by 48.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, each channel's control reads 0x0001_0002 (completion threshold 1 in bits 23:16, bit 1 set) and its status reads 0x0001_0001 (halted in bit 0, live completion count 1 in bits 23:16). The outputs then show halted = 1, run = 0, idle = 0 and irq = 0.
- R2: The channel is (byte address / 48) & 1, and the offset is byte address % 48. Offset 0x00 is control, 0x04 is status, 0x08 is the current-descriptor pointer and 0x10 is the tail-descriptor pointer; both pointers are plain 32-bit read/write registers. Any other offset reads 0 and ignores writes. Read data appears, together with rd_valid, one cycle after rd_en.
- R3: Control bit 1 (tail-pointer mode) always reads back as 1, whatever value was written.
- R4: Writing control with bit 0 (run) set, while no soft reset is pending, clears halted and idle. The run output follows control bit 0.
- R5: Writing the tail-descriptor pointer clears idle. An idle pulse from the datapath sets idle, which shows both on the idle output and in status bit 1.
- R6: Each completion pulse decrements the live completion count (status bits 23:16). A pulse that finds the count at 1 instead sets the completion interrupt (status bit 12) and reloads the count from control bits 23:16.
- R7: A completion pulse restarts the delay timer from control bits 31:24 when that field is non-zero. Status bits 31:24 show the timer. After delay × PRE_DIV cycles with no further completion, the timer sets the delay interrupt (status bit 13) and reloads the completion count from the threshold. A delay of 0 leaves the timer stopped.
- R8: irq is a registered output. It is high one cycle after any of status bits 14:12 is set while control has the same bit position set. It stays low for a pending bit whose control bit is clear.
- R9: Writing 1 to a status interrupt bit (14:12) clears that bit. A status write leaves halted and idle unchanged.
- R10: Any write to control reloads the live completion count from the newly written threshold.
- R11: A control write with bit 2 (soft reset) set, or any control write while that bit is pending, returns control to its reset value with bit 2 held, sets status to halted only and stops the delay timer. The pending bit blocks run from taking effect. Bit 2 always reads as 0, and a read of control clears the pending bit.
- R12: The two channels are independent: a completion, write or interrupt on one channel leaves the other channel's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address in the shared window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |
| done | input | 2 | Per-channel packet-completed pulse |
| idle_set | input | 2 | Per-channel datapath reached-tail pulse |
| irq | output | 2 | Per-channel interrupt line |
| run | output | 2 | Per-channel run level for the datapath |
| halted | output | 2 | Per-channel halted level |
| idle | output | 2 | Per-channel idle level |

## Verification
An off-by-one in the completion counter shows up in status bits 23:16 on the very next read. It also moves the completion interrupt to the wrong pulse in the train, so irq rises one completion early or late. A delay timer or prescaler that advances wrongly shifts the cycle on which irq rises, so the bench measures that cycle exactly: it must be delay × PRE_DIV + 1 edges after the completion edge. A soft-reset flag that is lost or cleared wrongly shows at once as run and halted taking the wrong levels after the next control write.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 8;
  localparam int WIN_BYTES = 48;
  localparam int OFS_W     = 6;

  // control bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_TAIL = 1;
  localparam int CB_SRST = 2;
  // status bit positions
  localparam int SB_HALT = 0;
  localparam int SB_IDLE = 1;
  // shared fields
  localparam int IRQ_LO = 12;
  localparam int IRQ_W  = 3;
  localparam int THR_LO = 16;
  localparam int DLY_LO = 24;

  localparam logic [WORD_W-1:0] CTRL_RST = 32'h0001_0002;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_CUR, SEL_TAIL
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      6'h00:   return SEL_CTRL;
      6'h04:   return SEL_STAT;
      6'h08:   return SEL_CUR;
      6'h10:   return SEL_TAIL;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dmac_prescaler.sv
`timescale 1ns/1ps
module dmac_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable,
  output logic tick
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (enable) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = enable && (cnt_q == LAST);

  // R7
  prescale_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/dmac_coalesce.sv
`timescale 1ns/1ps
module dmac_coalesce #(
  parameter int CW      = 8,
  parameter int PRE_DIV = 4,
  parameter logic [CW-1:0] RST_CNT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done_i,
  input  logic          reload_i,
  input  logic [CW-1:0] reload_val_i,
  input  logic          stop_i,
  input  logic [CW-1:0] thresh_i,
  input  logic [CW-1:0] delay_i,
  output logic          ioc_evt_o,
  output logic          dly_evt_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] tmr_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, tmr_q;
  logic tick, running, restart, expire;

  assign running = (tmr_q != '0);
  assign restart = done_i && (delay_i != '0) && !stop_i;
  assign expire  = running && tick && (tmr_q == ONE) && !restart && !stop_i;

  dmac_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .enable  (running),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst || stop_i) begin
      tmr_q <= '0;
    end else if (restart) begin
      tmr_q <= delay_i;
    end else if (running && tick) begin
      tmr_q <= tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_CNT;
    end else if (reload_i) begin
      cnt_q <= reload_val_i;
    end else if (done_i) begin
      cnt_q <= (cnt_q == ONE) ? thresh_i : cnt_q - 1'b1;
    end else if (expire) begin
      cnt_q <= thresh_i;
    end
  end

  assign ioc_evt_o = done_i && !reload_i && (cnt_q == ONE);
  assign dly_evt_o = expire;
  assign cnt_o     = cnt_q;
  assign tmr_o     = tmr_q;

  // R6
  ioc_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !reload_i && cnt_q == ONE) |=> (cnt_q == $past(thresh_i)));

  // R7
  tmr_expire_chk: assert property (@(posedge clk) disable iff (rst)
    (dly_evt_o && !reload_i && !done_i) |=> (tmr_q == '0 && cnt_q == $past(thresh_i)));

  // R7
  tmr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !stop_i && delay_i != '0) |=> (tmr_q == $past(delay_i)));
endmodule

// File: rtl/dmac_chan_regs.sv
`timescale 1ns/1ps
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic              idle_set_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              run_o,
  output logic              halted_o,
  output logic              idle_o
);
  logic [WORD_W-1:0]  ctrl_q, ctrl_new, cur_q, tail_q, stat_rd;
  logic               halted_q, idle_q, irq_line_q;
  logic [IRQ_W-1:0]   irq_bits_q, irq_clr, irq_set;
  logic               ctrl_wr, stat_wr, cur_wr, tail_wr, ctrl_rd, srst;
  logic               ioc_evt, dly_evt;
  logic [FIELD_W-1:0] cnt, tmr, reload_val;

  assign ctrl_wr = wr_i && (sel_i == SEL_CTRL);
  assign stat_wr = wr_i && (sel_i == SEL_STAT);
  assign cur_wr  = wr_i && (sel_i == SEL_CUR);
  assign tail_wr = wr_i && (sel_i == SEL_TAIL);
  assign ctrl_rd = rd_i && !wr_i && (sel_i == SEL_CTRL);

  always_comb begin
    ctrl_new          = wdata_i;
    ctrl_new[CB_TAIL] = 1'b1;
    ctrl_new[CB_SRST] = wdata_i[CB_SRST] | ctrl_q[CB_SRST];
  end

  assign srst       = ctrl_wr && ctrl_new[CB_SRST];
  assign reload_val = srst ? CTRL_RST[THR_LO +: FIELD_W] : ctrl_new[THR_LO +: FIELD_W];

  dmac_coalesce #(.CW(FIELD_W), .PRE_DIV(PRE_DIV), .RST_CNT(CTRL_RST[THR_LO +: FIELD_W])) u_coal (
    .clk          (clk),
    .rst          (rst),
    .done_i       (done_i),
    .reload_i     (ctrl_wr),
    .reload_val_i (reload_val),
    .stop_i       (srst),
    .thresh_i     (ctrl_q[THR_LO +: FIELD_W]),
    .delay_i      (ctrl_q[DLY_LO +: FIELD_W]),
    .ioc_evt_o    (ioc_evt),
    .dly_evt_o    (dly_evt),
    .cnt_o        (cnt),
    .tmr_o        (tmr)
  );

  // control register with sticky soft-reset flag
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
    end else if (srst) begin
      ctrl_q           <= CTRL_RST;
      ctrl_q[CB_SRST]  <= 1'b1;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_new;
    end else if (ctrl_rd) begin
      ctrl_q[CB_SRST] <= 1'b0;
    end
  end

  // halted / idle levels
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
    end else begin
      if (ctrl_wr && ctrl_new[CB_RUN]) begin
        halted_q <= 1'b0;
      end
      if ((ctrl_wr && ctrl_new[CB_RUN]) || tail_wr) begin
        idle_q <= 1'b0;
      end else if (idle_set_i) begin
        idle_q <= 1'b1;
      end
    end
  end

  // pending interrupt bits, write-one-to-clear
  assign irq_clr = stat_wr ? wdata_i[IRQ_LO +: IRQ_W] : '0;
  assign irq_set = {1'b0, dly_evt, ioc_evt};

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      irq_bits_q <= '0;
    end else begin
      irq_bits_q <= (irq_bits_q & ~irq_clr) | irq_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_line_q <= 1'b0;
    end else begin
      irq_line_q <= |(irq_bits_q & ctrl_q[IRQ_LO +: IRQ_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      if (cur_wr)  cur_q  <= wdata_i;
      if (tail_wr) tail_q <= wdata_i;
    end
  end

  always_comb begin
    stat_rd                     = '0;
    stat_rd[SB_HALT]            = halted_q;
    stat_rd[SB_IDLE]            = idle_q;
    stat_rd[IRQ_LO +: IRQ_W]    = irq_bits_q;
    stat_rd[THR_LO +: FIELD_W]  = cnt;
    stat_rd[DLY_LO +: FIELD_W]  = tmr;
  end

  always_comb begin
    case (sel_i)
      SEL_CTRL: begin
        rdata_o          = ctrl_q;
        rdata_o[CB_SRST] = 1'b0;
      end
      SEL_STAT: rdata_o = stat_rd;
      SEL_CUR:  rdata_o = cur_q;
      SEL_TAIL: rdata_o = tail_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o    = irq_line_q;
  assign run_o    = ctrl_q[CB_RUN];
  assign halted_o = halted_q;
  assign idle_o   = idle_q;

  // R11
  srst_state_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && (wdata_i[CB_SRST] || ctrl_q[CB_SRST])) |=> (halted_q && !idle_q && irq_bits_q == '0 && !run_o));

  // R4
  run_start_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata_i[CB_RUN] && !wdata_i[CB_SRST] && !ctrl_q[CB_SRST]) |=> (!halted_q && !idle_q));

  // R9
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wdata_i[IRQ_LO] && !ioc_evt) |=> !irq_bits_q[0]);

  // R3
  tail_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CB_TAIL]);
endmodule

// File: rtl/dmac_regbank.sv
`timescale 1ns/1ps
module dmac_regbank
  import dmac_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  input  logic [1:0]        done,
  input  logic [1:0]        idle_set,
  output logic [1:0]        irq,
  output logic [1:0]        run,
  output logic [1:0]        halted,
  output logic [1:0]        idle
);
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

  logic             ch_sel;
  logic [OFS_W-1:0] ofs;
  reg_sel_e         sel;
  logic [WORD_W-1:0] ch_rdata [NCH];

  assign ch_sel = 1'(addr / WIN);
  assign ofs    = OFS_W'(addr % WIN);
  assign sel    = decode_ofs(ofs);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmac_chan_regs #(.PRE_DIV(PRE_DIV)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_i       (wr_en && (ch_sel == 1'(i))),
      .rd_i       (rd_en && (ch_sel == 1'(i))),
      .sel_i      (sel),
      .wdata_i    (wdata),
      .done_i     (done[i]),
      .idle_set_i (idle_set[i]),
      .rdata_o    (ch_rdata[i]),
      .irq_o      (irq[i]),
      .run_o      (run[i]),
      .halted_o   (halted[i]),
      .idle_o     (idle[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= ch_rdata[ch_sel];
    end
  end
endmodule

// File: tb/sim_dmac_regbank.sv
`timescale 1ns/1ps
module sim_dmac_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [1:0]  done = '0, idle_set = '0;
  logic [1:0]  irq, run, halted, idle;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dmac_regbank #(.ADDR_W(8), .PRE_DIV(4)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .done(done),
    .idle_set(idle_set), .irq(irq), .run(run), .halted(halted), .idle(idle)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: pops expected read data as results arrive
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("unexpected read data", rdata, 32'hxxxx_xxxx);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_done(input int ch);
    @(negedge clk); done[ch] = 1'b1;
    @(negedge clk); done[ch] = 1'b0;
  endtask

  task automatic pulse_idle(input int ch);
    @(negedge clk); idle_set[ch] = 1'b1;
    @(negedge clk); idle_set[ch] = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int first;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 halted", {30'd0, halted}, 32'd3);
    chk("R1 run/idle/irq", {26'd0, run, idle, irq}, 32'd0);
    rd_exp(8'h00, 32'h0001_0002, "R1 ctrl ch0");
    rd_exp(8'h04, 32'h0001_0001, "R1 status ch0");
    rd_exp(8'h30, 32'h0001_0002, "R1 ctrl ch1");

    // R2 decode, pointers, aliasing, unmapped offset
    wr(8'h08, 32'hDEAD_BEE0);
    wr(8'h38, 32'h1234_5670);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_exp(8'h08, 32'hDEAD_BEE0, "R2 cur ch0");
    rd_exp(8'h38, 32'h1234_5670, "R2 cur ch1");
    rd_exp(8'h68, 32'hDEAD_BEE0, "R2 alias 0x68 to ch0");
    rd_exp(8'h0C, 32'h0000_0000, "R2 unmapped offset");

    // R3 tail mode reads 1
    wr(8'h00, 32'h0000_0000);
    rd_exp(8'h00, 32'h0000_0002, "R3 tail mode bit");

    // R4 run clears halted; R12 other channel untouched
    wr(8'h00, 32'h0003_1001);
    chk("R4 halted after run", {30'd0, halted}, 32'd2);
    chk("R4 run output", {30'd0, run}, 32'd1);
    rd_exp(8'h00, 32'h0003_1003, "R4 ctrl readback");

    // R6 completion counting
    rd_exp(8'h04, 32'h0003_0000, "R6 count loaded");
    pulse_done(0);
    pulse_done(0);
    rd_exp(8'h04, 32'h0001_0000, "R6 count after two");
    pulse_done(0);
    chk("R8 irq registered one cycle later", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    chk("R6 irq on third completion", {31'd0, irq[0]}, 32'd1);
    rd_exp(8'h04, 32'h0003_1000, "R6 ioc set and reload");

    // R9 write-one-to-clear, halted/idle not writable
    wr(8'h04, 32'h0000_0003);
    rd_exp(8'h04, 32'h0003_1000, "R9 status write w/o irq bits");
    wr(8'h04, 32'h0000_1000);
    @(negedge clk);
    chk("R9 irq dropped", {31'd0, irq[0]}, 32'd0);
    rd_exp(8'h04, 32'h0003_0000, "R9 ioc cleared");

    // R10 control write reloads; R8 mask gating
    wr(8'h00, 32'h0002_0001);
    pulse_done(0);
    rd_exp(8'h04, 32'h0001_0000, "R10 count before reload");
    wr(8'h00, 32'h0002_0001);
    rd_exp(8'h04, 32'h0002_0000, "R10 reload on ctrl write");
    pulse_done(0);
    pulse_done(0);
    @(negedge clk);
    chk("R8 masked pending keeps irq low", {31'd0, irq[0]}, 32'd0);
    rd_exp(8'h04, 32'h0002_1000, "R8 pending while masked");
    wr(8'h00, 32'h0002_1001);
    @(negedge clk);
    chk("R8 irq after unmask", {31'd0, irq[0]}, 32'd1);
    wr(8'h04, 32'h0000_1000);
    @(negedge clk);

    // R7 delay timer
    wr(8'h00, 32'h0305_2001);
    rd_exp(8'h00, 32'h0305_2003, "R7 ctrl readback");
    pulse_done(0);
    rd_exp(8'h04, 32'h0304_0000, "R7 live timer and count");
    for (int k = 0; k < 40 && !irq[0]; k++) @(negedge clk);
    chk("R7 delay irq raised", {31'd0, irq[0]}, 32'd1);
    rd_exp(8'h04, 32'h0005_2000, "R7 delay bit and count reload");
    wr(8'h04, 32'h0000_2000);
    @(negedge clk);
    chk("R9 delay irq cleared", {31'd0, irq[0]}, 32'd0);
    pulse_done(0);
    first = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (irq[0] && first == 0) first = k;
    end
    chk("R7 expiry cycle delay*PRE_DIV+1", first, 13);
    wr(8'h04, 32'h0000_2000);

    // R7 delay zero disables timer
    wr(8'h00, 32'h0005_2001);
    pulse_done(0);
    repeat (30) @(negedge clk);
    chk("R7 zero delay no irq", {31'd0, irq[0]}, 32'd0);
    rd_exp(8'h04, 32'h0004_0000, "R7 zero delay status");

    // R5 idle set by datapath, cleared by tail write
    pulse_idle(0);
    chk("R5 idle set", {30'd0, idle}, 32'd1);
    rd_exp(8'h04, 32'h0004_0002, "R5 idle in status");
    wr(8'h10, 32'h0000_0100);
    chk("R5 tail write clears idle", {30'd0, idle}, 32'd0);
    rd_exp(8'h10, 32'h0000_0100, "R5 tail readback");

    // R11 soft reset, sticky until control read
    wr(8'h00, 32'h0000_0004);
    chk("R11 halted after soft reset", {31'd0, halted[0]}, 32'd1);
    chk("R11 run cleared", {31'd0, run[0]}, 32'd0);
    wr(8'h00, 32'h0001_0001);
    chk("R11 pending reset blocks run", {30'd0, halted[0], run[0]}, 32'd2);
    rd_exp(8'h00, 32'h0001_0002, "R11 ctrl read hides reset bit");
    rd_exp(8'h04, 32'h0001_0001, "R11 status after soft reset");
    wr(8'h00, 32'h0001_0001);
    chk("R11 run after read clears reset", {30'd0, halted[0], run[0]}, 32'd1);

    // R12 channel independence
    wr(8'h30, 32'h0001_1001);
    pulse_done(1);
    @(negedge clk);
    chk("R12 irq only on ch1", {30'd0, irq}, 32'd2);
    rd_exp(8'h34, 32'h0001_1000, "R12 ch1 status");
    rd_exp(8'h04, 32'h0001_0000, "R12 ch0 status untouched");
    rd_exp(8'h38, 32'h1234_5670, "R12 ch1 pointer untouched");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule